// File: doc/BRIEF.md
# Emergency Shutdown Input Controller

This block watches an active-low emergency-stop pin of a motor-drive subsystem. The raw pin goes through a two-stage synchroniser and then a low-pulse qualifier whose minimum width is picked by a 3-bit code. A qualified low level latches a sticky shutdown flag. The flag is also the interrupt request line. Software can set the flag directly through a force strobe, and it clears the flag by writing 1 to a clear bit.

While the flag is set and the override is enabled, the six motor-drive pin outputs no longer follow the drive logic. Each pin instead takes a preset safe state: driven high, driven low, or released to high impedance. With the override disabled, the pins keep following the drive logic while the interrupt is still raised. Register decoding lives elsewhere: the block sees configuration levels and a write strobe that carries the force and clear data bits.

Top module: `estop_ctrl`

## Requirements
- R1: After reset the flag and interrupt are 0, every pin output equals its drive input, and every output enable is 1.
- R2: With filter code 000 and the pin enable set, a raw low level first sampled at a clock edge sets the flag at the third clock edge counted from that one (two synchroniser stages, then the flag register).
- R3: Filter codes 001, 010, 011 and 100 require 4, 8, 16 and 32 consecutive synchronised low samples. A low pulse seen on L clock edges sets the flag if and only if L is at least that width, and L of at least 1 is enough for code 000.
- R4: Any high sample restarts the low-sample count, so two short low pulses separated by a high sample never add up to a set.
- R5: When the pin enable is 0, the pin input never sets the flag, whatever its level or duration.
- R6: A write with the force bit at 1 sets the flag at the next clock edge, whether or not the pin is enabled and whatever the pin level.
- R7: A write with the clear bit at 1 clears the flag at the next edge. A write with the clear bit at 0 leaves the flag unchanged, and the flag holds its value when no write occurs.
- R8: If a set condition (qualified pin low or force) and a clear write happen in the same cycle, the flag ends up set.
- R9: While the flag is 1 and the override is enabled, each pin's output enable equals its safe-drive bit (1 means drive, 0 means high impedance). A driven pin outputs its safe-level bit and a released pin outputs 0.
- R10: While the override is disabled, the pins follow the drive inputs with all enables at 1, even when the flag is set.
- R11: The interrupt output equals the flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| estop_n_i | input | 1 | Raw emergency-stop pin, low requests shutdown |
| cfg_pin_en_i | input | 1 | 1 lets the pin set the flag |
| cfg_fw_code_i | input | 3 | Filter width code (000 none, 001..100 = 4/8/16/32 cycles) |
| cfg_ovr_en_i | input | 1 | 1 lets the flag take over the drive pins |
| cfg_safe_oe_i | input | N_DRV | Per-pin safe state: 1 drive, 0 high impedance |
| cfg_safe_lvl_i | input | N_DRV | Per-pin safe drive level |
| wr_en_i | input | 1 | Control write strobe, one cycle |
| wr_force_i | input | 1 | Force data bit of the write |
| wr_clr_i | input | 1 | Clear data bit of the write |
| drv_i | input | N_DRV | Normal motor-drive levels |
| pin_o | output | N_DRV | Final pin levels |
| pin_oe_o | output | N_DRV | Final pin output enables |
| flag_o | output | 1 | Sticky shutdown flag |
| irq_o | output | 1 | Shutdown interrupt request |

## Verification
The hardest case to reach from the ports is the exact qualification boundary. A pulse one sample shorter than the width must be rejected and a pulse of exactly the width must be accepted, and this must hold for each code, with the synchroniser delay in the path. The stimulus drives pulses of a controlled number of clock edges. Directed runs use lengths of width-1 and width for every code, plus a split pulse. Seeded random runs draw the code, length and enable, and a bench function predicts the flag from the length and the width. Same-cycle set and clear is reached by holding the pin low while a clear write arrives, and by writing force and clear together.

// File: rtl/estop_pkg.sv
package estop_pkg;
   localparam int FILT_MAX   = 32;
   localparam int FILT_CNT_W = $clog2(FILT_MAX + 1);
   localparam int FW_CODE_W  = 3;

   typedef enum logic [FW_CODE_W-1:0] {
      FW_NONE = 3'd0,
      FW_4    = 3'd1,
      FW_8    = 3'd2,
      FW_16   = 3'd3,
      FW_32   = 3'd4
   } fw_code_e;

   // Number of consecutive low samples needed; prohibited codes map to the widest window
   function automatic logic [FILT_CNT_W-1:0] fw_cycles(input logic [FW_CODE_W-1:0] code);
      logic [FILT_CNT_W-1:0] w;
      case (code)
         FW_NONE: w = '0;
         FW_4:    w = FILT_CNT_W'(4);
         FW_8:    w = FILT_CNT_W'(8);
         FW_16:   w = FILT_CNT_W'(16);
         default: w = FILT_CNT_W'(FILT_MAX);
      endcase
      return w;
   endfunction
endpackage

// File: rtl/estop_sync.sv
module estop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("estop_sync: STAGES must be at least 2");
      end
   endgenerate

   // idle level of the pin is high, so the chain resets to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '1;
      else        stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/estop_filter.sv
module estop_filter
   import estop_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 low_i,
   input  logic [FW_CODE_W-1:0] code_i,
   output logic                 qual_o
);
   localparam logic [FILT_CNT_W-1:0] RUN_SAT = FILT_CNT_W'(FILT_MAX);

   logic [FILT_CNT_W-1:0] run_q;
   logic [FILT_CNT_W-1:0] width_w;
   logic [FILT_CNT_W:0]   seen_w;

   // counts low samples already taken before the current one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_q <= '0;
      else if (!low_i)          run_q <= '0;
      else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
   end

   always_comb begin
      width_w = fw_cycles(code_i);
      seen_w  = {1'b0, run_q} + 1'b1;
      qual_o  = low_i && ((width_w == '0) || (seen_w >= {1'b0, width_w}));
   end
endmodule

// File: rtl/estop_flag.sv
module estop_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_set_i,
   input  logic sw_set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic set_w;

   assign set_w = pin_set_i | sw_set_i;

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_w) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/estop_outmux.sv
module estop_outmux #(
   parameter int N_DRV = 6
) (
   input  logic             take_i,
   input  logic [N_DRV-1:0] drv_i,
   input  logic [N_DRV-1:0] safe_oe_i,
   input  logic [N_DRV-1:0] safe_lvl_i,
   output logic [N_DRV-1:0] pin_o,
   output logic [N_DRV-1:0] pin_oe_o
);
   generate
      for (genvar i = 0; i < N_DRV; i++) begin : g_pin
         always_comb begin
            if (take_i) begin
               pin_oe_o[i] = safe_oe_i[i];
               pin_o[i]    = safe_oe_i[i] & safe_lvl_i[i];
            end else begin
               pin_oe_o[i] = 1'b1;
               pin_o[i]    = drv_i[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/estop_ctrl.sv
module estop_ctrl
   import estop_pkg::*;
#(
   parameter int N_DRV       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 estop_n_i,
   input  logic                 cfg_pin_en_i,
   input  logic [FW_CODE_W-1:0] cfg_fw_code_i,
   input  logic                 cfg_ovr_en_i,
   input  logic [N_DRV-1:0]     cfg_safe_oe_i,
   input  logic [N_DRV-1:0]     cfg_safe_lvl_i,
   input  logic                 wr_en_i,
   input  logic                 wr_force_i,
   input  logic                 wr_clr_i,
   input  logic [N_DRV-1:0]     drv_i,
   output logic [N_DRV-1:0]     pin_o,
   output logic [N_DRV-1:0]     pin_oe_o,
   output logic                 flag_o,
   output logic                 irq_o
);
   generate
      if (N_DRV < 1) begin : g_bad_ndrv
         $error("estop_ctrl: N_DRV must be at least 1");
      end
   endgenerate

   logic sync_n_w;
   logic sync_low_w;
   logic qual_w;
   logic flag_w;

   estop_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (estop_n_i),
      .q_o   (sync_n_w)
   );

   assign sync_low_w = ~sync_n_w;

   estop_filter u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .low_i  (sync_low_w),
      .code_i (cfg_fw_code_i),
      .qual_o (qual_w)
   );

   estop_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_set_i (qual_w & cfg_pin_en_i),
      .sw_set_i  (wr_en_i & wr_force_i),
      .clr_i     (wr_en_i & wr_clr_i),
      .flag_o    (flag_w)
   );

   estop_outmux #(.N_DRV(N_DRV)) u_omux (
      .take_i     (flag_w & cfg_ovr_en_i),
      .drv_i      (drv_i),
      .safe_oe_i  (cfg_safe_oe_i),
      .safe_lvl_i (cfg_safe_lvl_i),
      .pin_o      (pin_o),
      .pin_oe_o   (pin_oe_o)
   );

   assign flag_o = flag_w;
   assign irq_o  = flag_w;
endmodule

// File: rtl/estop_ctrl_chk.sv
module estop_ctrl_chk #(
   parameter int N_DRV = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_pin_en_i,
   input logic             cfg_ovr_en_i,
   input logic [N_DRV-1:0] cfg_safe_oe_i,
   input logic [N_DRV-1:0] drv_i,
   input logic             wr_en_i,
   input logic             wr_force_i,
   input logic             wr_clr_i,
   input logic [N_DRV-1:0] pin_o,
   input logic [N_DRV-1:0] pin_oe_o,
   input logic             flag_o,
   input logic             irq_o,
   input logic             qual,
   input logic             sync_low
);
   // R6
   force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_force_i) |=> flag_o);

   // R7
   clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_clr_i && !wr_force_i && !(cfg_pin_en_i && qual)) |=> !flag_o);

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !(wr_en_i && wr_clr_i)) |=> flag_o);

   // R5
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !(wr_en_i && wr_force_i) && !(cfg_pin_en_i && qual)) |=> !flag_o);

   // R8
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_clr_i && cfg_pin_en_i && qual) |=> flag_o);

   // R3
   qual_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> sync_low);

   // R9
   override_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && cfg_ovr_en_i) |-> (pin_oe_o == cfg_safe_oe_i));

   // R10
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o || !cfg_ovr_en_i) |-> (pin_o == drv_i && pin_oe_o == '1));

   // R11
   irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == flag_o);
endmodule

bind estop_ctrl estop_ctrl_chk #(.N_DRV(N_DRV)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_pin_en_i  (cfg_pin_en_i),
   .cfg_ovr_en_i  (cfg_ovr_en_i),
   .cfg_safe_oe_i (cfg_safe_oe_i),
   .drv_i         (drv_i),
   .wr_en_i       (wr_en_i),
   .wr_force_i    (wr_force_i),
   .wr_clr_i      (wr_clr_i),
   .pin_o         (pin_o),
   .pin_oe_o      (pin_oe_o),
   .flag_o        (flag_o),
   .irq_o         (irq_o),
   .qual          (qual_w),
   .sync_low      (sync_low_w)
);

// File: tb/estop_ctrl_tb.sv
module estop_ctrl_tb;
   localparam int N = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         estop_n = 1'b1;
   logic         pin_en = 1'b1;
   logic [2:0]   fw_code = 3'd0;
   logic         ovr_en = 1'b0;
   logic [N-1:0] safe_oe = '1;
   logic [N-1:0] safe_lvl = '0;
   logic         wr_en = 1'b0;
   logic         wr_force = 1'b0;
   logic         wr_clr = 1'b0;
   logic [N-1:0] drv = '0;
   logic [N-1:0] pin;
   logic [N-1:0] pin_oe;
   logic         flag;
   logic         irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   estop_ctrl #(.N_DRV(N), .SYNC_STAGES(2)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .estop_n_i      (estop_n),
      .cfg_pin_en_i   (pin_en),
      .cfg_fw_code_i  (fw_code),
      .cfg_ovr_en_i   (ovr_en),
      .cfg_safe_oe_i  (safe_oe),
      .cfg_safe_lvl_i (safe_lvl),
      .wr_en_i        (wr_en),
      .wr_force_i     (wr_force),
      .wr_clr_i       (wr_clr),
      .drv_i          (drv),
      .pin_o          (pin),
      .pin_oe_o       (pin_oe),
      .flag_o         (flag),
      .irq_o          (irq)
   );

   function automatic int width_of(input logic [2:0] c);
      case (c)
         3'd0: return 0;
         3'd1: return 4;
         3'd2: return 8;
         3'd3: return 16;
         default: return 32;
      endcase
   endfunction

   function automatic bit expect_set(input bit en, input logic [2:0] c, input int len);
      int w = width_of(c);
      if (w == 0) w = 1;
      return en && (len >= w);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input bit f, input bit c);
      @(negedge clk);
      wr_en = 1'b1; wr_force = f; wr_clr = c;
      @(negedge clk);
      wr_en = 1'b0; wr_force = 1'b0; wr_clr = 1'b0;
   endtask

   task automatic low_pulse(input int len);
      @(negedge clk);
      estop_n = 1'b0;
      repeat (len) @(negedge clk);
      estop_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic clean();
      estop_n = 1'b1;
      repeat (4) @(negedge clk);
      do_write(1'b0, 1'b1);
   endtask

   initial begin
      void'($urandom(32'h1D2C_5EED));
      drv = 6'b101100;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 flag", flag, 0);
      check("R1 pin", pin, drv);
      check("R1 oe", pin_oe, 6'h3f);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 flag after release", flag, 0);

      // R2 latency with code 000
      fw_code = 3'd0;
      @(negedge clk);
      estop_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R2 not yet after 2 edges", flag, 0);
      @(negedge clk);
      check("R2 set at 3rd edge", flag, 1);
      clean();

      // R3 boundary for every code
      for (int c = 1; c <= 4; c++) begin
         fw_code = 3'(c);
         low_pulse(width_of(3'(c)) - 1);
         check($sformatf("R3 code %0d width-1", c), flag, 0);
         clean();
         low_pulse(width_of(3'(c)));
         check($sformatf("R3 code %0d width", c), flag, 1);
         clean();
      end

      // R4 split pulse 3 low, 1 high, 3 low with width 4
      fw_code = 3'd1;
      @(negedge clk); estop_n = 1'b0;
      repeat (3) @(negedge clk); estop_n = 1'b1;
      @(negedge clk); estop_n = 1'b0;
      repeat (3) @(negedge clk); estop_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R4 split pulse", flag, 0);
      clean();

      // R5 pin disabled
      pin_en = 1'b0; fw_code = 3'd0;
      low_pulse(40);
      check("R5 disabled pin", flag, 0);
      // R6 force with pin disabled and pin high
      do_write(1'b1, 1'b0);
      check("R6 force", flag, 1);
      check("R11 irq", irq, 1);
      // R7 clear bit 0 write leaves flag
      do_write(1'b0, 1'b0);
      check("R7 write zero", flag, 1);
      do_write(1'b0, 1'b1);
      check("R7 clear", flag, 0);
      check("R11 irq cleared", irq, 0);
      pin_en = 1'b1;

      // R8 force and clear together
      do_write(1'b1, 1'b1);
      check("R8 force+clear", flag, 1);
      // R8 pin held low while clearing
      fw_code = 3'd0;
      @(negedge clk); estop_n = 1'b0;
      repeat (4) @(negedge clk);
      do_write(1'b0, 1'b1);
      check("R8 pin+clear", flag, 1);
      clean();
      check("R7 cleared after release", flag, 0);

      // R9 / R10 override
      safe_oe = 6'b110110; safe_lvl = 6'b011011; drv = 6'b000111;
      ovr_en = 1'b0;
      do_write(1'b1, 1'b0);
      check("R10 pins follow drv", pin, 6'b000111);
      check("R10 oe all on", pin_oe, 6'h3f);
      check("R10 irq still up", irq, 1);
      ovr_en = 1'b1;
      @(negedge clk);
      check("R9 oe", pin_oe, 6'b110110);
      check("R9 level", pin, 6'b010010);
      do_write(1'b0, 1'b1);
      check("R9 released after clear", pin, 6'b000111);

      // random mix
      for (int k = 0; k < 40; k++) begin
         logic [2:0] c = 3'($urandom_range(0, 4));
         int len = int'($urandom_range(1, 40));
         bit en = ($urandom_range(0, 3) != 0);
         logic [N-1:0] d = N'($urandom);
         logic [N-1:0] so = N'($urandom);
         logic [N-1:0] sl = N'($urandom);
         bit e;
         fw_code = c; pin_en = en; drv = d; safe_oe = so; safe_lvl = sl;
         low_pulse(len);
         e = expect_set(en, c, len);
         check($sformatf("R3 rand code %0d len %0d en %0d", c, len, en), flag, e);
         check("R11 rand irq", irq, e);
         if (e) begin
            check("R9 rand oe", pin_oe, so);
            check("R9 rand lvl", pin, so & sl);
         end else begin
            check("R10 rand pin", pin, d);
         end
         clean();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule